// File: doc/BRIEF.md
# Single-Accumulator Processor Core

This block is a very small processor with one working register, the accumulator. It steps through a program held in byte-addressable memory. Every instruction is three bytes long: an opcode byte, then a 16-bit operand address. The core fetches the instruction, decodes the opcode, reads or writes the operand word, updates the accumulator and then moves on to the next instruction. It supports four operations: load, store, add and multiply. A halt opcode stops the core. Any opcode it does not recognise also stops it and raises an error flag.

All memory traffic uses one request/ready port that moves a whole 16-bit word on each accepted transfer. The core holds a request, with its address, write enable and write data, until the memory returns ready in the same cycle. Every output is a register, so the memory sees stable values for the whole cycle. A typical use is a short straight-line program such as computing `A = B*C + D` and writing the result back to memory.

Top module: `acc_core`

## Requirements
- R1: While reset is high and in the first cycle after it, the core drives mem_req=1, mem_addr=0x0000, mem_we=0, halted=0 and err=0, so the first fetch starts at byte address 0.
- R2: An instruction occupies three bytes at pc, pc+1 and pc+2: the opcode, the operand address high byte and the operand address low byte. It is fetched as a word read at pc (opcode in bits 15:8) and a word read at pc+2 (address low byte in bits 15:8). The next instruction starts at pc+3.
- R3: Opcode 0x01 (load) reads the operand word and puts it in the accumulator.
- R4: Opcode 0x03 (add) reads the operand word and puts (accumulator + word) mod 2^16 in the accumulator.
- R5: Opcode 0x04 (multiply) reads the operand word and puts the low 16 bits of accumulator × word in the accumulator.
- R6: Opcode 0x02 (store) performs one write of the accumulator to the operand address, big-endian: the high byte goes to the address and the low byte to the address plus one. No other byte changes. mem_we is high only during that write.
- R7: A transfer completes in a cycle where mem_req and mem_ready are both high. Until then mem_req, mem_addr, mem_we and mem_wdata stay unchanged.
- R8: Opcode 0xFF sets halted=1 and leaves err=0. After that mem_req stays low and the core issues no further access until reset.
- R9: Any other opcode value sets halted=1 and err=1. The core does not fetch the operand address or run any later instruction.
- R10: Each access takes one cycle when memory is always ready. A load, add, multiply or store therefore takes three cycles, and the halt fetch takes one. The program load, multiply, add, store, halt keeps mem_req high for exactly 13 cycles after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Memory access requested |
| mem_addr | output | 16 | Byte address of the word accessed (big-endian word) |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wdata | output | 16 | Word to write |
| mem_rdata | input | 16 | Word read, valid when mem_ready is high |
| mem_ready | input | 1 | Memory completes the current access this cycle |
| halted | output | 1 | Core has stopped |
| err | output | 1 | Core stopped on an unknown opcode |

## Verification
Each accepted transfer takes effect at the clock edge where mem_req and mem_ready are both high. The next access appears on the registered port outputs in the following cycle, and halted rises one cycle after the halt opcode word is accepted. The bench samples on the falling edge, so a transfer it records is the one that the next rising edge completes. With memory always ready it checks the exact order of transfers and the 13-cycle request count. With random memory latency it checks only results that do not depend on timing: the memory contents once halted is set, and the stability of each held request. Flags and the quiet bus after halt are checked over a window of cycles once halted has been seen.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OPC_LOAD  = 8'h01;
  localparam logic [BYTE_W-1:0] OPC_STORE = 8'h02;
  localparam logic [BYTE_W-1:0] OPC_ADD   = 8'h03;
  localparam logic [BYTE_W-1:0] OPC_MUL   = 8'h04;
  localparam logic [BYTE_W-1:0] OPC_HALT  = 8'hFF;

  typedef enum logic [2:0] {
    ST_FETCH_OP,
    ST_FETCH_LO,
    ST_OPERAND,
    ST_WRITE,
    ST_STOP
  } seq_state_e;

  function automatic logic opc_runs(input logic [BYTE_W-1:0] opc);
    return (opc == OPC_LOAD) || (opc == OPC_STORE) ||
           (opc == OPC_ADD)  || (opc == OPC_MUL);
  endfunction
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [BYTE_W-1:0] opc,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result
);
  localparam int PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0] product;
  logic [DATA_W-1:0] sum;

  always_comb begin
    product = PROD_W'(acc) * PROD_W'(operand);
    sum     = acc + operand;
    unique case (opc)
      OPC_ADD: result = sum;
      OPC_MUL: result = product[DATA_W-1:0];
      default: result = operand;
    endcase
  end
endmodule

// File: rtl/acc_accreg.sv
module acc_accreg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (ld) acc <= din;
  end

  // R3: the accumulator changes only when an operand read completes
  assert_acc_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(acc));
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] acc,
  output logic              acc_ld,
  output logic [BYTE_W-1:0] opc,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              halted,
  output logic              err
);
  localparam int WORD_BYTES = DATA_W / BYTE_W;
  localparam int ADDR_BYTES = ADDR_W / BYTE_W;
  localparam int INSN_LEN   = 1 + ADDR_BYTES;
  localparam int HI_W       = ADDR_W - BYTE_W;

  seq_state_e        st;
  logic [ADDR_W-1:0] pc;
  logic [HI_W-1:0]   addr_hi;
  logic              done;
  logic [BYTE_W-1:0] top_byte;

  assign done     = mem_req && mem_ready;
  assign top_byte = mem_rdata[DATA_W-1 -: BYTE_W];
  assign acc_ld   = done && (st == ST_OPERAND);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_FETCH_OP;
      pc        <= '0;
      addr_hi   <= '0;
      opc       <= '0;
      mem_req   <= 1'b1;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      halted    <= 1'b0;
      err       <= 1'b0;
    end else if (done) begin
      unique case (st)
        ST_FETCH_OP: begin
          opc     <= top_byte;
          addr_hi <= mem_rdata[DATA_W-BYTE_W-1 -: HI_W];
          if (opc_runs(top_byte)) begin
            st       <= ST_FETCH_LO;
            mem_addr <= pc + ADDR_W'(WORD_BYTES);
          end else begin
            st      <= ST_STOP;
            mem_req <= 1'b0;
            halted  <= 1'b1;
            err     <= (top_byte != OPC_HALT);
          end
        end
        ST_FETCH_LO: begin
          pc       <= pc + ADDR_W'(INSN_LEN);
          mem_addr <= {addr_hi, top_byte};
          if (opc == OPC_STORE) begin
            st        <= ST_WRITE;
            mem_we    <= 1'b1;
            mem_wdata <= acc;
          end else begin
            st <= ST_OPERAND;
          end
        end
        ST_OPERAND: begin
          st       <= ST_FETCH_OP;
          mem_addr <= pc;
        end
        ST_WRITE: begin
          st       <= ST_FETCH_OP;
          mem_addr <= pc;
          mem_we   <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // R7: a pending request stays unchanged until accepted
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                 $stable(mem_we) && $stable(mem_wdata)));
  // R8: once stopped, the bus stays quiet
  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !mem_req));
  // R9: error only together with halt
  assert_err_halts_R9: assert property (@(posedge clk) disable iff (rst)
    err |-> halted);
  // R6: writes only during the store data phase
  assert_we_store_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_req && st == ST_WRITE));
  // R2: next fetch begins three bytes on
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (done && st == ST_FETCH_LO) |=> (pc == $past(pc) + ADDR_W'(INSN_LEN)));
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              halted,
  output logic              err
);
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] alu_out;
  logic [BYTE_W-1:0] opc;
  logic              acc_ld;

  acc_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .acc(acc), .acc_ld(acc_ld), .opc(opc), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .halted(halted), .err(err)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .opc(opc), .acc(acc), .operand(mem_rdata), .result(alu_out)
  );

  acc_accreg #(.DATA_W(DATA_W)) u_acc (
    .clk(clk), .rst(rst), .ld(acc_ld), .din(alu_out), .acc(acc)
  );
endmodule

// File: tb/acc_core_bench.sv
module acc_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req, mem_we, mem_ready, halted, err;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  int errors = 0;
  int checks = 0;
  bit zero_wait = 1'b1;
  int lat_cur = 0;
  int wait_cnt = 0;
  int req_cycles = 0;
  int hold_bad = 0;
  int n_tr = 0;
  logic [15:0] tr_addr [0:31];
  logic        tr_we   [0:31];
  logic        p_pend;
  logic [15:0] p_addr, p_wdata;
  logic        p_we;
  logic [7:0]  mem [0:255];

  always #10 clk = ~clk;

  acc_core u_acc_core (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .halted(halted), .err(err)
  );

  assign mem_ready = mem_req && (wait_cnt >= lat_cur);
  assign mem_rdata = {mem[mem_addr[7:0]], mem[mem_addr[7:0] + 8'd1]};

  always @(posedge clk) begin
    if (rst) begin
      wait_cnt <= 0;
      lat_cur  <= zero_wait ? 0 : int'($urandom_range(0, 3));
    end else if (mem_req) begin
      if (mem_ready) begin
        if (mem_we) begin
          mem[mem_addr[7:0]]        <= mem_wdata[15:8];
          mem[mem_addr[7:0] + 8'd1] <= mem_wdata[7:0];
        end
        wait_cnt <= 0;
        lat_cur  <= zero_wait ? 0 : int'($urandom_range(0, 3));
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      p_pend <= 1'b0;
    end else begin
      if (mem_req) req_cycles <= req_cycles + 1;
      if (p_pend && !(mem_req && mem_addr == p_addr && mem_we == p_we &&
                      mem_wdata == p_wdata))
        hold_bad <= hold_bad + 1;
      p_pend  <= mem_req && !mem_ready;
      p_addr  <= mem_addr;
      p_we    <= mem_we;
      p_wdata <= mem_wdata;
      if (mem_req && mem_ready && n_tr < 32) begin
        tr_addr[n_tr] <= mem_addr;
        tr_we[n_tr]   <= mem_we;
        n_tr <= n_tr + 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] calc(input logic [15:0] b, c, d);
    logic [31:0] p;
    p = b * c;
    return p[15:0] + d;
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic put_insn(input int a, input logic [7:0] op, input logic [15:0] opnd);
    mem[a] = op; mem[a+1] = opnd[15:8]; mem[a+2] = opnd[7:0];
  endtask

  task automatic put_word(input int a, input logic [15:0] v);
    mem[a] = v[15:8]; mem[a+1] = v[7:0];
  endtask

  function automatic logic [15:0] get_word(input int a);
    return {mem[a], mem[a+1]};
  endfunction

  task automatic start();
    @(posedge clk); #2 rst = 1'b1;
    @(posedge clk);
    @(posedge clk); #2 rst = 1'b0;
    req_cycles = 0; hold_bad = 0; n_tr = 0;
  endtask

  task automatic wait_halt(input string req);
    int n = 0;
    while (!halted && n < 3000) begin @(negedge clk); n++; end
    check({req, " halted"}, halted, 1'b1);
  endtask

  task automatic abcd_prog(input logic [15:0] b, c, d);
    clear_mem();
    put_insn(0, 8'h01, 16'h0080);
    put_insn(3, 8'h04, 16'h0082);
    put_insn(6, 8'h03, 16'h0084);
    put_insn(9, 8'h02, 16'h0086);
    mem[12] = 8'hFF;
    put_word(8'h80, b); put_word(8'h82, c); put_word(8'h84, d);
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] b, c, d;
    void'($urandom(32'd1234));
    zero_wait = 1'b1;
    abcd_prog(16'd7, 16'd6, 16'd5);
    @(negedge clk);
    // R1: reset state
    check("R1 req", mem_req, 1'b1);
    check("R1 addr", mem_addr, 16'h0000);
    check("R1 we", mem_we, 1'b0);
    check("R1 flags", {halted, err}, 2'b00);
    start();
    @(negedge clk);
    check("R1 first cycle", {mem_req, mem_addr, mem_we, halted, err}, {1'b1, 16'h0, 3'b000});
    wait_halt("R10");
    // R2, R3, R4, R5, R6 on the A=B*C+D program
    check("R5 R4 R6 result", get_word(8'h86), calc(16'd7, 16'd6, 16'd5));
    check("R10 request cycles", req_cycles, 13);
    check("R2 transfer count", n_tr, 13);
    begin
      logic [15:0] ea [0:12];
      ea = '{16'h0, 16'h2, 16'h80, 16'h3, 16'h5, 16'h82, 16'h6, 16'h8,
             16'h84, 16'h9, 16'hB, 16'h86, 16'hC};
      for (int i = 0; i < 13; i++) begin
        check("R2 fetch order", tr_addr[i], ea[i]);
        check("R6 write enable", tr_we[i], (i == 11) ? 1'b1 : 1'b0);
      end
    end
    // R8: halt opcode, quiet bus
    check("R8 err", err, 1'b0);
    begin
      int busy = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (mem_req) busy++; end
      check("R8 quiet bus", busy, 0);
    end

    // R7: random latency with random operands
    zero_wait = 1'b0;
    for (int t = 0; t < 10; t++) begin
      b = 16'($urandom); c = 16'($urandom); d = 16'($urandom);
      abcd_prog(b, c, d);
      start();
      wait_halt("R7");
      check("R7 random result", get_word(8'h86), calc(b, c, d));
      check("R7 request held", hold_bad, 0);
    end

    // R4 R5 wrap corners
    zero_wait = 1'b1;
    abcd_prog(16'hFFFF, 16'hFFFF, 16'hFFFF);
    start(); wait_halt("R5");
    check("R5 R4 wrap", get_word(8'h86), 16'h0000);
    abcd_prog(16'h0100, 16'h0100, 16'h1234);
    start(); wait_halt("R5");
    check("R5 low half", get_word(8'h86), 16'h1234);

    // R3 R6: load then store twice, odd addresses, neighbours untouched
    clear_mem();
    put_insn(0, 8'h01, 16'h0091);
    put_insn(3, 8'h02, 16'h00A1);
    put_insn(6, 8'h02, 16'h00B0);
    mem[9] = 8'hFF;
    put_word(8'h91, 16'hBEEF);
    mem[8'hA0] = 8'h5A; mem[8'hA3] = 8'hC3;
    start(); wait_halt("R6");
    check("R3 R6 odd store", {mem[8'hA1], mem[8'hA2]}, 16'hBEEF);
    check("R6 second store", get_word(8'hB0), 16'hBEEF);
    check("R6 neighbours", {mem[8'hA0], mem[8'hA3]}, 16'h5AC3);

    // R9: unknown opcode stops before a later store
    clear_mem();
    put_insn(0, 8'h01, 16'h0080);
    put_insn(3, 8'h37, 16'h0000);
    put_insn(6, 8'h02, 16'h0090);
    put_word(8'h80, 16'h4321);
    start(); wait_halt("R9");
    check("R9 err", err, 1'b1);
    check("R9 requests", req_cycles, 4);
    begin
      int busy = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (mem_req) busy++; end
      check("R9 quiet bus", busy, 0);
    end
    check("R9 no later store", get_word(8'h90), 16'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule